// File: doc/BRIEF.md
# Ready/Sync Bus Cycle Stall Controller

This block decides, on every bus cycle of a processor core, whether the core moves on to its next cycle or freezes in the current one. The core's cycle sequencer presents the request for its next bus cycle: an address, a direction and a flag that marks an opcode fetch. The controller latches that request onto registered bus outputs and answers with a one-clock advance pulse each time a request has been consumed. Each bus cycle spans `CYC_CLKS` clocks, and the first clock of each period is the phase-one slot.

An external ready line, after a `SYNC_STAGES`-deep synchronizer, is sampled once per period in the phase-one slot. A read cycle that sees ready low is stretched by whole periods until a later phase-one sample sees ready high. During the stretch the address, direction and fetch marker stay fixed. Write cycles never stretch. A low ready that overlaps a write stalls the next read only if it is still low at that read's sample. Because the fetch marker is high for the whole of a fetch cycle, an external agent can gate ready from it to step one instruction at a time. It can also step single cycles, insert wait states for slow memory, or hold the bus for short DMA windows.

Top module: `ready_stall_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are all zero. On the first edge with `rst` low, the request on `req_*` is loaded, and `core_adv` is high for the following clock.
- R2: With ready high, each bus cycle lasts exactly `CYC_CLKS` clocks. `core_adv` is high for one clock at the start of each cycle, the same clock in which `addr_out`, `write_out` and `sync_out` first show the request that was on `req_*` at the loading edge.
- R3: `rdy_pin` is delayed by `SYNC_STAGES` flops and sampled only in the phase-one slot (the first clock of each period). A low level during any other clock has no effect on cycle length.
- R4: A read cycle (`write_out` = 0) whose phase-one sample sees ready low is extended by whole periods until a phase-one sample sees ready high. Meanwhile `addr_out`, `write_out` and `sync_out` stay unchanged and `core_adv` stays low.
- R5: A write cycle (`write_out` = 1) always lasts exactly `CYC_CLKS` clocks, whatever the ready level.
- R6: A ready low that covers a write defers to the next read. That read stalls if ready is still low at its own phase-one sample, and runs at full speed if ready has returned high.
- R7: `sync_out` is 1 on every clock of a cycle loaded with `req_fetch` = 1, stall clocks included, and 0 on every clock of other cycles.
- R8: `frozen` rises on the clock after a phase-one sample that stalls a read. It falls on the clock after the phase-one sample that releases the read. It is never high during a write cycle.
- R9: `addr_valid` goes to 1 with the first loaded cycle after reset and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_pin | input | 1 | External ready line, asynchronous to the clock |
| req_addr | input | ADDR_W | Address of the next bus cycle requested by the sequencer |
| req_write | input | 1 | Direction of the next cycle: 1 = write, 0 = read |
| req_fetch | input | 1 | 1 when the next cycle is an opcode fetch |
| core_adv | output | 1 | One-clock pulse: request consumed, the core may advance |
| sync_out | output | 1 | Registered opcode-fetch marker for the current cycle |
| addr_out | output | ADDR_W | Registered bus address, held through stalls |
| write_out | output | 1 | Registered direction of the current cycle |
| addr_valid | output | 1 | High once a cycle has been put on the bus |
| frozen | output | 1 | High while the current read is held by ready |

## Verification
The bench attacks the sampling point by driving ready low on every clock except the one that reaches the phase-one sample; a controller that sampled at the wrong clock, or on every clock, would stretch those cycles. It also drives ready low only onto write samples, which would catch a controller that held a stale deferred stall into the following read. A long low window that starts in a write and runs into a fetch read must stall that fetch while keeping the fetch marker and address fixed; a wrong design would advance early or drop the marker. A pseudo-random ready stream then mixes one-period wait states with multi-period holds and checks every stalled cycle against a whole number of periods.

// File: rtl/stall_pkg.sv
package stall_pkg;

  typedef enum logic {
    XFER_READ  = 1'b0,
    XFER_WRITE = 1'b1
  } xfer_dir_e;

  // A sampled-low ready only holds read transfers.
  function automatic logic want_hold(input xfer_dir_e dir, input logic rdy_sampled);
    return (dir == XFER_READ) && !rdy_sampled;
  endfunction

endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_async,
  output logic rdy_synced
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= rdy_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b1;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rdy_synced = chain_q[STAGES-1];
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int CYC_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  output logic at_sample,
  output logic at_end
);
  localparam int CNT_W = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  // Reset parks the counter on the last slot so the first edge loads a cycle.
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_sample = (cnt_q == '0);
  assign at_end    = (cnt_q == LAST);
endmodule

// File: rtl/stall_decider.sv
module stall_decider
  import stall_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      at_sample,
  input  logic      at_end,
  input  xfer_dir_e cur_dir,
  input  logic      rdy_s,
  output logic      hold_q,
  output logic      cyc_done
);
  always_ff @(posedge clk) begin
    if (rst)            hold_q <= 1'b0;
    else if (at_sample) hold_q <= want_hold(cur_dir, rdy_s);
  end

  assign cyc_done = at_end && !hold_q;
endmodule

// File: rtl/bus_cycle_reg.sv
module bus_cycle_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              nxt_write,
  input  logic              nxt_fetch,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_fetch,
  output logic              bus_live,
  output logic              adv_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_fetch <= 1'b0;
      bus_live  <= 1'b0;
      adv_pulse <= 1'b0;
    end else begin
      adv_pulse <= load;
      if (load) begin
        bus_addr  <= nxt_addr;
        bus_write <= nxt_write;
        bus_fetch <= nxt_fetch;
        bus_live  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ready_stall_ctrl.sv
module ready_stall_ctrl
  import stall_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CYC_CLKS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_pin,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              core_adv,
  output logic              sync_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              write_out,
  output logic              addr_valid,
  output logic              frozen
);
  logic rdy_s;
  logic at_sample;
  logic at_end;
  logic hold_q;
  logic cyc_done;

  rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .rdy_async  (rdy_pin),
    .rdy_synced (rdy_s)
  );

  phase_counter #(.CYC_CLKS(CYC_CLKS)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .at_sample (at_sample),
    .at_end    (at_end)
  );

  stall_decider u_decide (
    .clk       (clk),
    .rst       (rst),
    .at_sample (at_sample),
    .at_end    (at_end),
    .cur_dir   (xfer_dir_e'(write_out)),
    .rdy_s     (rdy_s),
    .hold_q    (hold_q),
    .cyc_done  (cyc_done)
  );

  bus_cycle_reg #(.ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .load      (cyc_done),
    .nxt_addr  (req_addr),
    .nxt_write (req_write),
    .nxt_fetch (req_fetch),
    .bus_addr  (addr_out),
    .bus_write (write_out),
    .bus_fetch (sync_out),
    .bus_live  (addr_valid),
    .adv_pulse (core_adv)
  );

  assign frozen = hold_q;
endmodule

// File: rtl/ready_stall_ctrl_chk.sv
module ready_stall_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_fetch,
  input logic              core_adv,
  input logic              sync_out,
  input logic [ADDR_W-1:0] addr_out,
  input logic              write_out,
  input logic              addr_valid,
  input logic              frozen
);
  // R2: the advance pulse is one clock wide
  p_adv_single_r2: assert property (@(posedge clk) disable iff (rst)
    core_adv |=> !core_adv);

  // R2: the address shown with the pulse is the one requested at the loading edge
  p_load_addr_r2: assert property (@(posedge clk) disable iff (rst)
    core_adv |-> (addr_out == $past(req_addr)));

  // R4: a held cycle keeps its bus outputs still
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    frozen |=> ($stable(addr_out) && $stable(write_out) && $stable(sync_out)));

  // R4: no advance while held
  p_hold_no_adv_r4: assert property (@(posedge clk) disable iff (rst)
    frozen |=> !core_adv);

  // R7: the fetch marker comes from the loaded request
  p_sync_load_r7: assert property (@(posedge clk) disable iff (rst)
    core_adv |-> (sync_out == $past(req_fetch)));

  // R5 and R8: a write is never held
  p_write_free_r8: assert property (@(posedge clk) disable iff (rst)
    write_out |-> !frozen);

  // R9: once valid, stays valid
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> addr_valid);
endmodule

bind ready_stall_ctrl ready_stall_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_addr   (req_addr),
  .req_fetch  (req_fetch),
  .core_adv   (core_adv),
  .sync_out   (sync_out),
  .addr_out   (addr_out),
  .write_out  (write_out),
  .addr_valid (addr_valid),
  .frozen     (frozen)
);

// File: tb/test_ready_stall_ctrl.sv
`timescale 1ns/1ps
module test_ready_stall_ctrl;
  localparam int AW   = 16;
  localparam int CYC  = 2;
  localparam int SYN  = 2;
  localparam int NREQ = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdy = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic req_fetch = 1'b0;
  logic core_adv, sync_out, write_out, addr_valid, frozen;
  logic [AW-1:0] addr_out;

  always #2 clk = ~clk;

  ready_stall_ctrl #(.ADDR_W(AW), .CYC_CLKS(CYC), .SYNC_STAGES(SYN)) i_ready_stall_ctrl (
    .clk(clk), .rst(rst), .rdy_pin(rdy), .req_addr(req_addr), .req_write(req_write),
    .req_fetch(req_fetch), .core_adv(core_adv), .sync_out(sync_out), .addr_out(addr_out),
    .write_out(write_out), .addr_valid(addr_valid), .frozen(frozen)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] p_addr [NREQ];
  bit p_wr [NREQ];
  bit p_fe [NREQ];

  // reference model state: what the outputs should show in the current clock
  int m_pos;
  bit m_hold, m_adv, m_wr, m_sync, m_valid;
  logic [AW-1:0] m_addr;
  bit hist[$];

  int active = -1;
  int nxt = 0;
  int clk_no = 0;
  int last_adv = 0;
  int hold_clks = 0;
  logic [7:0] lf = 8'hA5;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pos = CYC - 1; m_hold = 0; m_adv = 0; m_wr = 0; m_sync = 0; m_valid = 0; m_addr = '0;
    hist.delete();
    for (int k = 0; k < SYN; k++) hist.push_back(1'b1);
  endtask

  task automatic model_step();
    bit syn, done;
    syn = hist[hist.size() - SYN];
    hist.push_back(rdy);
    if (hist.size() > 8) void'(hist.pop_front());
    done = (m_pos == CYC - 1) && !m_hold;
    if (m_pos == 0) m_hold = !m_wr && !syn;
    m_adv = done;
    if (done) begin
      m_addr = req_addr; m_wr = req_write; m_sync = req_fetch; m_valid = 1;
    end
    m_pos = (m_pos == CYC - 1) ? 0 : m_pos + 1;
  endtask

  function automatic bit pick_rdy();
    int ahead, tgt;
    bit is_s;
    ahead = m_pos + SYN;
    is_s = (ahead % CYC) == 0;
    tgt = active + ahead / CYC;
    if (active < 8) return 1'b1;
    if (active < 16) return is_s;                         // R3: low only off the sample
    if (active < 23) return !(is_s && tgt < NREQ && p_wr[tgt]); // low only at write samples
    if (active < 31) return hold_clks >= 10;              // long low window
    return lf[1:0] != 2'b00;
  endfunction

  task automatic present();
    int j;
    j = (nxt < NREQ) ? nxt : NREQ - 1;
    req_addr = p_addr[j]; req_write = p_wr[j]; req_fetch = p_fe[j];
  endtask

  task automatic compare();
    check(core_adv == m_adv, (m_hold ? "R4" : "R2"), "core_adv", core_adv, m_adv);
    check(addr_out == m_addr, "R4", "addr_out", addr_out, m_addr);
    check(write_out == m_wr, "R5", "write_out", write_out, m_wr);
    check(sync_out == m_sync, "R7", "sync_out", sync_out, m_sync);
    check(frozen == m_hold, "R8", "frozen", frozen, m_hold);
    check(addr_valid == m_valid, "R9", "addr_valid", addr_valid, m_valid);
  endtask

  task automatic cycle_ended();
    int len;
    len = clk_no - last_adv;
    if (active >= 0 && active < NREQ) begin
      if (p_wr[active]) check(len == CYC, "R5", "write length", len, CYC);
      else              check(len % CYC == 0, "R4", "read length in periods", len % CYC, 0);
      if (active >= 8 && active < 16)
        check(len == CYC, "R3", "length with off-sample low ready", len, CYC);
      if (active >= 16 && active < 23 && !p_wr[active])
        check(len == CYC, "R6", "read after cleared deferral", len, CYC);
      if (active == 25)
        check(len > CYC, "R6", "deferred stall on fetch read", len, CYC + 1);
    end
    last_adv = clk_no;
  endtask

  initial begin
    for (int j = 0; j < NREQ; j++) begin
      p_addr[j] = AW'(16'h1000 + j * 37);
      p_wr[j] = (j % 3) == 2;
      p_fe[j] = (j % 3) == 0;
    end
    p_wr[24] = 1; p_fe[24] = 0;
    p_fe[25] = 1;

    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(core_adv == 0, "R1", "core_adv in reset", core_adv, 0);
    check(sync_out == 0, "R1", "sync_out in reset", sync_out, 0);
    check(addr_out == 0, "R1", "addr_out in reset", addr_out, 0);
    check(write_out == 0, "R1", "write_out in reset", write_out, 0);
    check(addr_valid == 0, "R1", "addr_valid in reset", addr_valid, 0);
    check(frozen == 0, "R1", "frozen in reset", frozen, 0);

    rst = 1'b0;
    present();
    rdy = 1'b1;
    model_step();

    while (active < NREQ - 1) begin
      @(negedge clk);
      clk_no++;
      if (clk_no == 1) begin
        check(core_adv == 1, "R1", "first advance after reset", core_adv, 1);
        check(addr_out == p_addr[0], "R1", "first address", addr_out, p_addr[0]);
      end
      compare();
      if (core_adv) begin
        cycle_ended();
        active = nxt;
        nxt++;
      end
      if (active >= 23 && active < 31) hold_clks++;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      present();
      rdy = pick_rdy();
      model_step();
      if (clk_no > 20000) begin
        check(1'b0, "R2", "watchdog expired", clk_no, 20000);
        break;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule